// File: doc/BRIEF.md
# Reference Clock Frequency Classifier

This block works out which of six standard crystal frequencies drives the system clock. It counts system clock cycles over a window that a slow 32 kHz timebase defines. The timebase is treated as exact, and the system clock rate is the unknown.

A pulse on `start_i` arms one measurement. The block first waits until the slow tick count has moved `LEAD_TICKS` past its value at arming. At that point it takes a snapshot of a free-running system-clock counter. A second snapshot follows `WIN_TICKS` slow ticks later. The difference between the two snapshots is doubled when the oscillator pre-divide-by-2 status is set. It is then compared against a ladder of thresholds.

The results are a frequency class, a select code, a recommended pre-divider value and a table index for downstream configuration. `done_o` is a one-cycle strobe that marks new results. It carries no ready signal, so the consumer cannot apply back-pressure and must take the results in that cycle or read them later from the held outputs.

The slow tick count reaches the system clock domain through a Gray-coded copy and a synchroniser chain.

Top module: `refclk_classifier`

## Requirements
- R1: After reset, `done_o`=0, `class_o`=0, `sel_o`=0, `prediv_o`=1 and `index_o`=0.
- R2: The synchronised slow count is latched when `start_i` is accepted. The first snapshot is taken in the first cycle in which the synchronised slow count equals the latched value plus `LEAD_TICKS` (modulo 2^SLOW_W). The second snapshot is taken when it equals that target plus `WIN_TICKS`. The elapsed count is the second snapshot minus the first, modulo 2^CNT_W, so a counter wrap inside the window gives the true cycle count.
- R3: When `div2_stat_i` is 1 at the second snapshot, the elapsed count is doubled before classification. When it is 0, the count is used unchanged.
- R4: Let c be the scaled count. The class is decided by the first strict test that holds, in this order: c > TH_38M4 gives class 5 (38.4 MHz); c > TH_26M gives class 4 (26 MHz); c > TH_24M gives class 3 (24 MHz); c > TH_19M2 gives class 2 (19.2 MHz); c > TH_13M gives class 1 (13 MHz). Any other c gives class 0 (12 MHz).
- R5: The select code is 4 for class 5, 3 for class 4, 2 for class 2, 1 for class 1 and 0 for class 0. Class 3 (24 MHz) has no code of its own and gives select 0.
- R6: When `legacy_i` is 1 at the second snapshot and the select code is above 2, `prediv_o`=2 and `index_o` = select/2 (integer division). In every other case `prediv_o`=1 and `index_o` equals the select code.
- R7: Each measurement raises `done_o` for exactly one cycle. The results change only in the cycle where `done_o` is high and hold their values until the next strobe.
- R8: A `start_i` pulse during a measurement is ignored. It neither restarts nor re-targets the window, and it does not produce an extra `done_o`.
- R9: The slow tick count enters the system clock domain as Gray code, so the synchronised copy changes by at most one bit per system clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (the clock being measured) |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| slow_clk | input | 1 | Known 32 kHz timebase |
| start_i | input | 1 | Arms one measurement when the block is idle |
| div2_stat_i | input | 1 | Oscillator pre-divide-by-2 status; doubles the count |
| legacy_i | input | 1 | Marks the older chip variant for the pre-divider rule |
| done_o | output | 1 | One-cycle strobe: new results are valid |
| class_o | output | 3 | Frequency class, 0 = 12 MHz up to 5 = 38.4 MHz |
| sel_o | output | 3 | Select code for the class |
| prediv_o | output | 2 | Recommended input pre-divider (1 or 2) |
| index_o | output | 3 | Recommended parameter table index |

## Verification
The bench sweeps the ratio between the slow period and the system clock period in steps of one. Because each count lands exactly on every threshold, the bench checks that each threshold is strict (a count equal to a threshold falls to the class below it), so a design that used greater-or-equal would move every boundary count up one class.

The bench uses a narrow system counter, so many windows wrap. A design that did not subtract modulo 2^CNT_W would return a huge or negative count and report a class that is badly wrong.

The sweep is repeated with the divide-by-2 status set and with the chip variant alternating. This catches a doubling that was missed or applied twice, the 24 MHz case mapped to a non-zero select code, and an index taken without halving. An extra start pulse fired in the middle of a window must not cause a second strobe or a shifted result.

// File: rtl/refclk_cls_pkg.sv
package refclk_cls_pkg;

  typedef enum logic [2:0] {
    FC_12M  = 3'd0,
    FC_13M  = 3'd1,
    FC_19M2 = 3'd2,
    FC_24M  = 3'd3,
    FC_26M  = 3'd4,
    FC_38M4 = 3'd5
  } freq_class_e;

  // Select code per class; 24 MHz has none and falls back to 0.
  function automatic logic [2:0] sel_code(input freq_class_e c);
    case (c)
      FC_38M4: sel_code = 3'd4;
      FC_26M:  sel_code = 3'd3;
      FC_19M2: sel_code = 3'd2;
      FC_13M:  sel_code = 3'd1;
      default: sel_code = 3'd0;
    endcase
  endfunction

  function automatic logic [15:0] bin_to_gray16(input logic [15:0] b);
    bin_to_gray16 = b ^ (b >> 1);
  endfunction

endpackage

// File: rtl/slow_tick_gray.sv
// Free-running tick counter in the slow domain, published as registered Gray code.
module slow_tick_gray #(
  parameter int SLOW_W = 16
) (
  input  logic              slow_clk,
  input  logic              rst_n,
  output logic [SLOW_W-1:0] gray_o
);
  logic [SLOW_W-1:0] bin_q;
  logic [SLOW_W-1:0] bin_nx;

  assign bin_nx = bin_q + SLOW_W'(1);

  always_ff @(posedge slow_clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_o <= '0;
    end else begin
      bin_q  <= bin_nx;
      gray_o <= bin_nx ^ (bin_nx >> 1);
    end
  end
endmodule

// File: rtl/gray_sync_decode.sv
// Synchroniser chain for a Gray-coded count, then conversion back to binary.
module gray_sync_decode #(
  parameter int SLOW_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOW_W-1:0] gray_i,
  output logic [SLOW_W-1:0] bin_o
);
  logic [SLOW_W-1:0] stg_q [SYNC_STAGES];

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= gray_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  logic [SLOW_W-1:0] gsync;
  assign gsync = stg_q[SYNC_STAGES-1];

  always_comb begin
    bin_o[SLOW_W-1] = gsync[SLOW_W-1];
    for (int i = SLOW_W - 2; i >= 0; i--) begin
      bin_o[i] = bin_o[i+1] ^ gsync[i];
    end
  end

  assert_gray_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gsync ^ $past(gsync)) <= 1);

endmodule

// File: rtl/refclk_window_meas.sv
// Aligns to the slow timebase, takes two snapshots of the fast counter and
// hands on the (optionally doubled) elapsed count.
module refclk_window_meas #(
  parameter int SLOW_W     = 16,
  parameter int CNT_W      = 32,
  parameter int LEAD_TICKS = 20,
  parameter int WIN_TICKS  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [SLOW_W-1:0] slow_now_i,
  input  logic              div2_i,
  input  logic              legacy_i,
  output logic              res_valid_o,
  output logic [CNT_W:0]    res_cnt_o,
  output logic              res_legacy_o
);
  localparam logic [SLOW_W-1:0] LEAD_V = SLOW_W'(LEAD_TICKS);
  localparam logic [SLOW_W-1:0] WIN_V  = SLOW_W'(WIN_TICKS);

  typedef enum logic [1:0] {MS_IDLE, MS_ALIGN, MS_WINDOW} meas_st_e;

  meas_st_e          st_q;
  logic [SLOW_W-1:0] tgt_q;
  logic [CNT_W-1:0]  fcnt_q;
  logic [CNT_W-1:0]  cap_q;
  logic [CNT_W-1:0]  elapsed;
  logic              hit;

  assign hit     = (slow_now_i == tgt_q);
  assign elapsed = fcnt_q - cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fcnt_q <= '0;
    else        fcnt_q <= fcnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= MS_IDLE;
      tgt_q        <= '0;
      cap_q        <= '0;
      res_valid_o  <= 1'b0;
      res_cnt_o    <= '0;
      res_legacy_o <= 1'b0;
    end else begin
      res_valid_o <= 1'b0;
      case (st_q)
        MS_IDLE: begin
          if (start_i) begin
            tgt_q <= slow_now_i + LEAD_V;
            st_q  <= MS_ALIGN;
          end
        end
        MS_ALIGN: begin
          if (hit) begin
            cap_q <= fcnt_q;
            tgt_q <= tgt_q + WIN_V;
            st_q  <= MS_WINDOW;
          end
        end
        MS_WINDOW: begin
          if (hit) begin
            res_cnt_o    <= div2_i ? {elapsed, 1'b0} : {1'b0, elapsed};
            res_legacy_o <= legacy_i;
            res_valid_o  <= 1'b1;
            st_q         <= MS_IDLE;
          end
        end
        default: st_q <= MS_IDLE;
      endcase
    end
  end

  initial begin
    assert (LEAD_TICKS >= 1 && WIN_TICKS >= 1);
  end

  assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == MS_ALIGN && start_i && !hit) |=> (st_q == MS_ALIGN && $stable(tgt_q)));

  assert_window_follows_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == MS_ALIGN && hit) |=> (st_q == MS_WINDOW && tgt_q == $past(tgt_q) + WIN_V));

  assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |=> !res_valid_o);

endmodule

// File: rtl/refclk_ladder.sv
// Threshold ladder, select code and pre-divider/index recommendation.
module refclk_ladder
  import refclk_cls_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int TH_38M4 = 19000,
  parameter int TH_26M  = 15200,
  parameter int TH_24M  = 13000,
  parameter int TH_19M2 = 9000,
  parameter int TH_13M  = 7600
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           valid_i,
  input  logic [CNT_W:0] cnt_i,
  input  logic           legacy_i,
  output logic           done_o,
  output freq_class_e    class_o,
  output logic [2:0]     sel_o,
  output logic [1:0]     prediv_o,
  output logic [2:0]     index_o
);
  localparam int SW = CNT_W + 1;
  localparam logic [SW-1:0] L_38M4 = SW'(TH_38M4);
  localparam logic [SW-1:0] L_26M  = SW'(TH_26M);
  localparam logic [SW-1:0] L_24M  = SW'(TH_24M);
  localparam logic [SW-1:0] L_19M2 = SW'(TH_19M2);
  localparam logic [SW-1:0] L_13M  = SW'(TH_13M);

  freq_class_e cls_n;
  logic [2:0]  sel_n;
  logic [1:0]  pdv_n;
  logic [2:0]  idx_n;

  always_comb begin
    if      (cnt_i > L_38M4) cls_n = FC_38M4;
    else if (cnt_i > L_26M)  cls_n = FC_26M;
    else if (cnt_i > L_24M)  cls_n = FC_24M;
    else if (cnt_i > L_19M2) cls_n = FC_19M2;
    else if (cnt_i > L_13M)  cls_n = FC_13M;
    else                     cls_n = FC_12M;
    sel_n = sel_code(cls_n);
    if (legacy_i && sel_n > 3'd2) begin
      pdv_n = 2'd2;
      idx_n = sel_n >> 1;
    end else begin
      pdv_n = 2'd1;
      idx_n = sel_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o   <= 1'b0;
      class_o  <= FC_12M;
      sel_o    <= 3'd0;
      prediv_o <= 2'd1;
      index_o  <= 3'd0;
    end else begin
      done_o <= valid_i;
      if (valid_i) begin
        class_o  <= cls_n;
        sel_o    <= sel_n;
        prediv_o <= pdv_n;
        index_o  <= idx_n;
      end
    end
  end

  assert_done_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_results_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(class_o) || !$stable(sel_o) || !$stable(index_o)) |-> done_o);

  assert_no_code_for_24m_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (class_o == FC_24M) |-> (sel_o == 3'd0));

  assert_halved_index_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (prediv_o == 2'd2) |-> (sel_o > 3'd2 && index_o == (sel_o >> 1)));

  assert_prediv_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (prediv_o == 2'd1) || (prediv_o == 2'd2));

endmodule

// File: rtl/refclk_classifier.sv
module refclk_classifier
  import refclk_cls_pkg::*;
#(
  parameter int SLOW_W      = 16,
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2,
  parameter int LEAD_TICKS  = 20,
  parameter int WIN_TICKS   = 20,
  parameter int TH_38M4     = 19000,
  parameter int TH_26M      = 15200,
  parameter int TH_24M      = 13000,
  parameter int TH_19M2     = 9000,
  parameter int TH_13M      = 7600
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slow_clk,
  input  logic       start_i,
  input  logic       div2_stat_i,
  input  logic       legacy_i,
  output logic       done_o,
  output logic [2:0] class_o,
  output logic [2:0] sel_o,
  output logic [1:0] prediv_o,
  output logic [2:0] index_o
);
  logic [SLOW_W-1:0] slow_gray;
  logic [SLOW_W-1:0] slow_now;
  logic              res_valid;
  logic [CNT_W:0]    res_cnt;
  logic              res_legacy;
  freq_class_e       cls;

  slow_tick_gray #(.SLOW_W(SLOW_W)) u_tick (
    .slow_clk (slow_clk),
    .rst_n    (rst_n),
    .gray_o   (slow_gray)
  );

  gray_sync_decode #(.SLOW_W(SLOW_W), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .gray_i (slow_gray),
    .bin_o  (slow_now)
  );

  refclk_window_meas #(
    .SLOW_W(SLOW_W), .CNT_W(CNT_W), .LEAD_TICKS(LEAD_TICKS), .WIN_TICKS(WIN_TICKS)
  ) u_meas (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .slow_now_i   (slow_now),
    .div2_i       (div2_stat_i),
    .legacy_i     (legacy_i),
    .res_valid_o  (res_valid),
    .res_cnt_o    (res_cnt),
    .res_legacy_o (res_legacy)
  );

  refclk_ladder #(
    .CNT_W(CNT_W), .TH_38M4(TH_38M4), .TH_26M(TH_26M), .TH_24M(TH_24M),
    .TH_19M2(TH_19M2), .TH_13M(TH_13M)
  ) u_ladder (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_i  (res_valid),
    .cnt_i    (res_cnt),
    .legacy_i (res_legacy),
    .done_o   (done_o),
    .class_o  (cls),
    .sel_o    (sel_o),
    .prediv_o (prediv_o),
    .index_o  (index_o)
  );

  assign class_o = cls;

endmodule

// File: tb/tb_refclk_classifier.sv
`timescale 1ns/1ps
module tb_refclk_classifier;
  localparam int LEAD = 2;
  localparam int WIN  = 2;
  localparam int T5 = 190, T4 = 152, T3 = 130, T2 = 90, T1 = 76;

  logic clk = 1'b0, rst_n = 1'b0, slow_clk = 1'b0;
  logic start_i = 1'b0, div2_stat_i = 1'b0, legacy_i = 1'b0;
  logic done_o;
  logic [2:0] class_o, sel_o, index_o;
  logic [1:0] prediv_o;

  int n_chk = 0, n_fail = 0;
  int half_ns = 150;

  refclk_classifier #(
    .SLOW_W(4), .CNT_W(8), .SYNC_STAGES(2), .LEAD_TICKS(LEAD), .WIN_TICKS(WIN),
    .TH_38M4(T5), .TH_26M(T4), .TH_24M(T3), .TH_19M2(T2), .TH_13M(T1)
  ) dut (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .start_i(start_i),
    .div2_stat_i(div2_stat_i), .legacy_i(legacy_i), .done_o(done_o),
    .class_o(class_o), .sel_o(sel_o), .prediv_o(prediv_o), .index_o(index_o)
  );

  always #5 clk = ~clk;

  initial begin
    #2;
    forever begin
      #(half_ns) slow_clk = ~slow_clk;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #5_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  // One measurement with slow period = ratio * 10 ns; optional extra start mid-window.
  task automatic measure(input int ratio, input bit d2, input bit leg, input bit extra);
    int c, ecls, esel, epdv, eidx, waited, dones;
    half_ns = ratio * 5;
    repeat (3) @(posedge slow_clk);
    @(negedge clk);
    div2_stat_i = d2; legacy_i = leg; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    waited = 0;
    while (!done_o && waited < 20000) begin
      @(negedge clk);
      waited++;
      if (extra && waited == ratio) start_i = 1'b1;
      else start_i = 1'b0;
    end
    start_i = 1'b0;
    c = WIN * ratio * (d2 ? 2 : 1);
    if      (c > T5) begin ecls = 5; esel = 4; end
    else if (c > T4) begin ecls = 4; esel = 3; end
    else if (c > T3) begin ecls = 3; esel = 0; end
    else if (c > T2) begin ecls = 2; esel = 2; end
    else if (c > T1) begin ecls = 1; esel = 1; end
    else             begin ecls = 0; esel = 0; end
    if (leg && esel > 2) begin epdv = 2; eidx = esel / 2; end
    else                 begin epdv = 1; eidx = esel; end
    check("R7", "done seen", int'(done_o), 1);
    // R2 window alignment/wrap, R3 scaling, R4 ladder
    check("R4", $sformatf("class ratio=%0d d2=%0d", ratio, d2), int'(class_o), ecls);
    check("R5", $sformatf("sel ratio=%0d", ratio), int'(sel_o), esel);
    check("R6", $sformatf("prediv ratio=%0d leg=%0d", ratio, leg), int'(prediv_o), epdv);
    check("R6", $sformatf("index ratio=%0d leg=%0d", ratio, leg), int'(index_o), eidx);
    @(negedge clk);
    check("R7", "done dropped", int'(done_o), 0);
    if (extra) begin
      dones = 0;
      repeat (ratio * 8) begin
        @(negedge clk);
        if (done_o) dones++;
      end
      check("R8", "no extra done after mid-window start", dones, 0);
      check("R8", "class held after mid-window start", int'(class_o), ecls);
      check("R2", "elapsed count unaffected by mid-window start", int'(sel_o), esel);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check("R1", "done", int'(done_o), 0);
    check("R1", "class", int'(class_o), 0);
    check("R1", "sel", int'(sel_o), 0);
    check("R1", "prediv", int'(prediv_o), 1);
    check("R1", "index", int'(index_o), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1", "done after release", int'(done_o), 0);

    // R2/R4: undivided sweep, every threshold hit exactly, counter wraps often
    for (int r = 30; r <= 110; r++) measure(r, 1'b0, r[0], 1'b0);
    // R3: doubling with the divide status set
    for (int r = 18; r <= 54; r++) measure(r, 1'b1, ~r[0], 1'b0);

    // R7: results held long after the strobe
    measure(100, 1'b0, 1'b1, 1'b0);
    repeat (300) @(negedge clk);
    check("R7", "class held", int'(class_o), 5);
    check("R7", "index held", int'(index_o), 2);

    // R8: extra start inside the window
    measure(70, 1'b0, 1'b0, 1'b1);
    measure(50, 1'b1, 1'b1, 1'b1);

    finish_run();
  end
endmodule